// File: doc/BRIEF.md
# Packet ring with allocate, dispatch and retire indices

This block is an on-chip ring of fixed-size packet slots. It holds local copies of packets fetched from a command queue in memory. Three free-running indices track each slot. The write index counts slots handed out to the fetch engine. The dispatch index counts packets issued downstream. The read index counts packets retired. A slot lies between read and dispatch while it is issued but not yet finished. It lies between dispatch and write while it is allocated but not yet issued. Every other slot is free.

The fetch side first requests a run of slots together with the host address of the first packet. Once a packet's bytes arrive, the fetch side writes them into the slot for that packet's index. The issue side takes packets in order and receives each packet's data and host address with it. Packets may finish in any order. Each slot keeps a completion flag, and the read index only moves past an unbroken run of finished packets, oldest first. A status output reports whether the oldest unfinished packet is also the only unfinished one. An ordering barrier can use this to decide when it may lift.

Top module: `pkt_ring`

## Requirements
- R1: After reset, the write, dispatch and read indices are 0. The free count equals SLOTS, the in-flight count is 0, and both `disp_ready_o` and `last_out_o` are 0.
- R2: An allocation of N slots with N no greater than the free count is granted in the same cycle. The write index then rises by N at the next edge, and the free count is always SLOTS minus (write index minus read index).
- R3: An allocation of N slots with N greater than the free count is refused: `alloc_grant_o` is 0 and no index changes.
- R4: On a granted allocation, the slot for index write+i stores host address base + 64*i, for i from 0 to N-1. `disp_addr_o` shows the stored address of the slot at the dispatch index.
- R5: A fill stores its 64-byte packet in slot (index mod SLOTS) and marks that slot filled. `disp_data_o` shows the packet in the slot at the dispatch index.
- R6: `disp_ready_o` is 1 exactly when dispatch is below write and the dispatch slot is filled. A take while ready raises the dispatch index by 1 at the next edge. A take while not ready has no effect.
- R7: A completion sets the flag of slot (index mod SLOTS), and completions may arrive in any order. When the read index is below dispatch and its slot is flagged, the read index rises by 1 at the next edge. That retirement clears the slot's completion and filled flags, so a reused slot needs a new fill before it can be dispatched.
- R8: The in-flight count equals dispatch minus read, and read ≤ dispatch ≤ write holds at all times.
- R9: `last_out_o` is 1 exactly when all of the following hold: read differs from dispatch, the read slot is not flagged complete, and every index after read and before dispatch is flagged complete.
- R10: The indices keep rising past SLOTS without resetting. The slot for any index is the index modulo SLOTS, where SLOTS is a power of two and at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_cnt_i | input | CNT_W | Number of slots requested |
| alloc_base_i | input | ADDR_W | Host address of the first packet requested |
| alloc_grant_o | output | 1 | Request accepted this cycle |
| fill_valid_i | input | 1 | Packet data write |
| fill_idx_i | input | IDX_W | Index of the packet being written |
| fill_data_i | input | PKT_W | Packet bytes |
| disp_take_i | input | 1 | Issue the packet at the dispatch index |
| disp_ready_o | output | 1 | Packet at the dispatch index is ready to issue |
| disp_idx_o | output | IDX_W | Dispatch index |
| disp_data_o | output | PKT_W | Packet at the dispatch slot |
| disp_addr_o | output | ADDR_W | Host address of the dispatch slot |
| done_valid_i | input | 1 | Completion report |
| done_idx_i | input | IDX_W | Index of the completed packet |
| wr_idx_o | output | IDX_W | Write index |
| rd_idx_o | output | IDX_W | Read index |
| free_cnt_o | output | CNT_W | Free slot count |
| inflight_o | output | CNT_W | Issued but not retired packet count |
| last_out_o | output | 1 | Oldest unfinished packet is the only unfinished one |

## Verification
`alloc_grant_o` is combinational on the request and the current indices, so it is checked while the request is still applied. The write and dispatch indices, stored data and addresses, filled flags and the outputs derived from them all move one edge after the input is sampled. A completion lands at one edge, and the read index moves at the following edge, one slot per edge. The bench applies inputs just after a rising edge and holds them for one cycle. A model steps once per edge and queues the expected outputs, and those are compared at the next falling edge, where both the input-dependent grant and the new registered state are stable.

// File: rtl/pkt_ring_pkg.sv
package pkt_ring_pkg;
  localparam int unsigned PKT_BYTES_DEF = 64;

  typedef struct packed {
    logic filled;
    logic done;
  } slot_flag_t;
endpackage

// File: rtl/pkt_ring_idx.sv
module pkt_ring_idx #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned IDX_W = 64,
  localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_take_i,
  input  logic [CNT_W-1:0] alloc_cnt_i,
  input  logic             disp_take_i,
  input  logic             retire_i,
  output logic [IDX_W-1:0] wr_q_o,
  output logic [IDX_W-1:0] disp_q_o,
  output logic [IDX_W-1:0] rd_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q_o   <= '0;
      disp_q_o <= '0;
      rd_q_o   <= '0;
    end else begin
      if (alloc_take_i) wr_q_o <= wr_q_o + IDX_W'(alloc_cnt_i);
      if (disp_take_i)  disp_q_o <= disp_q_o + IDX_W'(1);
      if (retire_i)     rd_q_o <= rd_q_o + IDX_W'(1);
    end
  end
endmodule

// File: rtl/pkt_ring_store.sv
module pkt_ring_store
  import pkt_ring_pkg::*;
#(
  parameter int unsigned SLOTS     = 8,
  parameter int unsigned PKT_BYTES = 64,
  parameter int unsigned ADDR_W    = 64,
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned CNT_W    = $clog2(SLOTS + 1),
  localparam int unsigned PKT_W    = PKT_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_take_i,
  input  logic [CNT_W-1:0]  alloc_cnt_i,
  input  logic [ADDR_W-1:0] alloc_base_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic              fill_valid_i,
  input  logic [SLOT_W-1:0] fill_slot_i,
  input  logic [PKT_W-1:0]  fill_data_i,
  input  logic              done_valid_i,
  input  logic [SLOT_W-1:0] done_slot_i,
  input  logic              retire_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  input  logic [SLOT_W-1:0] disp_slot_i,
  output logic [PKT_W-1:0]  disp_data_o,
  output logic [ADDR_W-1:0] disp_addr_o,
  output logic [SLOTS-1:0]  filled_o,
  output logic [SLOTS-1:0]  done_o
);
  logic [PKT_W-1:0]  data_q [SLOTS];
  logic [ADDR_W-1:0] addr_q [SLOTS];
  slot_flag_t        flag_q [SLOTS];
  logic [SLOTS-1:0]  alloc_hit;
  logic [SLOT_W-1:0] alloc_off [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    // distance of this slot from the first slot of the run, modulo SLOTS
    assign alloc_off[s] = SLOT_W'(s) - wr_slot_i;
    assign alloc_hit[s] = alloc_take_i && (CNT_W'(alloc_off[s]) < alloc_cnt_i);
    assign filled_o[s]  = flag_q[s].filled;
    assign done_o[s]    = flag_q[s].done;
  end

  always_ff @(posedge clk_i) begin
    for (int s = 0; s < SLOTS; s++) begin
      if (alloc_hit[s])
        addr_q[s] <= alloc_base_i + ADDR_W'(alloc_off[s]) * ADDR_W'(PKT_BYTES);
      if (fill_valid_i && fill_slot_i == SLOT_W'(s))
        data_q[s] <= fill_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SLOTS; s++) flag_q[s] <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (retire_i && rd_slot_i == SLOT_W'(s)) flag_q[s] <= '0;
        if (fill_valid_i && fill_slot_i == SLOT_W'(s)) flag_q[s].filled <= 1'b1;
        if (done_valid_i && done_slot_i == SLOT_W'(s)) flag_q[s].done <= 1'b1;
      end
    end
  end

  assign disp_data_o = data_q[disp_slot_i];
  assign disp_addr_o = addr_q[disp_slot_i];
endmodule

// File: rtl/pkt_ring_last.sv
module pkt_ring_last #(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0]  done_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  input  logic [CNT_W-1:0]  inflight_i,
  output logic              last_o
);
  logic              younger_done;
  logic [SLOT_W-1:0] pos;

  always_comb begin
    younger_done = 1'b1;
    pos = rd_slot_i;
    for (int k = 1; k < SLOTS; k++) begin
      pos = rd_slot_i + SLOT_W'(k);
      if (CNT_W'(k) < inflight_i && !done_i[pos]) younger_done = 1'b0;
    end
    last_o = (inflight_i != '0) && !done_i[rd_slot_i] && younger_done;
  end
endmodule

// File: rtl/pkt_ring.sv
module pkt_ring #(
  parameter int unsigned SLOTS     = 8,
  parameter int unsigned PKT_BYTES = pkt_ring_pkg::PKT_BYTES_DEF,
  parameter int unsigned IDX_W     = 64,
  parameter int unsigned ADDR_W    = 64,
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned CNT_W    = $clog2(SLOTS + 1),
  localparam int unsigned PKT_W    = PKT_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [CNT_W-1:0]  alloc_cnt_i,
  input  logic [ADDR_W-1:0] alloc_base_i,
  output logic              alloc_grant_o,
  input  logic              fill_valid_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [PKT_W-1:0]  fill_data_i,
  input  logic              disp_take_i,
  output logic              disp_ready_o,
  output logic [IDX_W-1:0]  disp_idx_o,
  output logic [PKT_W-1:0]  disp_data_o,
  output logic [ADDR_W-1:0] disp_addr_o,
  input  logic              done_valid_i,
  input  logic [IDX_W-1:0]  done_idx_i,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic [CNT_W-1:0]  free_cnt_o,
  output logic [CNT_W-1:0]  inflight_o,
  output logic              last_out_o
);
  logic [IDX_W-1:0]  wr_q, disp_q, rd_q;
  logic [SLOTS-1:0]  filled, done;
  logic [CNT_W-1:0]  used;
  logic [SLOT_W-1:0] wr_slot, rd_slot, disp_slot, fill_slot, done_slot;
  logic              disp_take, retire;

  assign wr_slot   = SLOT_W'(wr_q);
  assign rd_slot   = SLOT_W'(rd_q);
  assign disp_slot = SLOT_W'(disp_q);
  assign fill_slot = SLOT_W'(fill_idx_i);
  assign done_slot = SLOT_W'(done_idx_i);

  assign used          = CNT_W'(wr_q - rd_q);
  assign free_cnt_o    = CNT_W'(SLOTS) - used;
  assign inflight_o    = CNT_W'(disp_q - rd_q);
  assign alloc_grant_o = alloc_valid_i && (alloc_cnt_i <= free_cnt_o);
  assign disp_ready_o  = (disp_q != wr_q) && filled[disp_slot];
  assign disp_take     = disp_take_i && disp_ready_o;
  assign retire        = (rd_q != disp_q) && done[rd_slot];

  pkt_ring_idx #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_idx (
    .clk_i, .rst_ni,
    .alloc_take_i (alloc_grant_o),
    .alloc_cnt_i,
    .disp_take_i  (disp_take),
    .retire_i     (retire),
    .wr_q_o       (wr_q),
    .disp_q_o     (disp_q),
    .rd_q_o       (rd_q)
  );

  pkt_ring_store #(.SLOTS(SLOTS), .PKT_BYTES(PKT_BYTES), .ADDR_W(ADDR_W)) u_store (
    .clk_i, .rst_ni,
    .alloc_take_i (alloc_grant_o),
    .alloc_cnt_i,
    .alloc_base_i,
    .wr_slot_i    (wr_slot),
    .fill_valid_i,
    .fill_slot_i  (fill_slot),
    .fill_data_i,
    .done_valid_i,
    .done_slot_i  (done_slot),
    .retire_i     (retire),
    .rd_slot_i    (rd_slot),
    .disp_slot_i  (disp_slot),
    .disp_data_o,
    .disp_addr_o,
    .filled_o     (filled),
    .done_o       (done)
  );

  pkt_ring_last #(.SLOTS(SLOTS)) u_last (
    .done_i     (done),
    .rd_slot_i  (rd_slot),
    .inflight_i (inflight_o),
    .last_o     (last_out_o)
  );

  assign wr_idx_o   = wr_q;
  assign rd_idx_o   = rd_q;
  assign disp_idx_o = disp_q;
endmodule

// File: rtl/pkt_ring_chk.sv
module pkt_ring_chk #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned IDX_W = 64,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             alloc_valid_i,
  input logic [CNT_W-1:0] alloc_cnt_i,
  input logic             alloc_grant_o,
  input logic             disp_take_i,
  input logic             disp_ready_o,
  input logic [IDX_W-1:0] disp_idx_o,
  input logic [IDX_W-1:0] wr_idx_o,
  input logic [IDX_W-1:0] rd_idx_o,
  input logic [CNT_W-1:0] inflight_o,
  input logic             last_out_o
);
  p_alloc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_grant_o |=> wr_idx_o == $past(wr_idx_o) + IDX_W'($past(alloc_cnt_i)));

  p_refuse_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && !alloc_grant_o) |=> wr_idx_o == $past(wr_idx_o));

  p_occupancy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_idx_o - rd_idx_o) <= IDX_W'(SLOTS));

  p_disp_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_take_i && disp_ready_o) |=> disp_idx_o == $past(disp_idx_o) + IDX_W'(1));

  p_disp_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(disp_take_i && disp_ready_o) |=> $stable(disp_idx_o));

  p_retire_one_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rd_idx_o - $past(rd_idx_o)) <= IDX_W'(1));

  p_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_o <= disp_idx_o && disp_idx_o <= wr_idx_o);

  p_last_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_out_o |-> inflight_o != '0);
endmodule

bind pkt_ring pkt_ring_chk #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .alloc_valid_i, .alloc_cnt_i, .alloc_grant_o,
  .disp_take_i, .disp_ready_o, .disp_idx_o, .wr_idx_o, .rd_idx_o,
  .inflight_o, .last_out_o
);

// File: tb/pkt_ring_bench.sv
module pkt_ring_bench;
  localparam int  SLOTS = 8;
  localparam int  CNT_W = 4;
  localparam int  PKT_W = 512;
  localparam time CLK_T = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              alloc_valid = 1'b0;
  logic [CNT_W-1:0]  alloc_cnt = '0;
  logic [63:0]       alloc_base = '0;
  logic              alloc_grant;
  logic              fill_valid = 1'b0;
  logic [63:0]       fill_idx = '0;
  logic [PKT_W-1:0]  fill_data = '0;
  logic              disp_take = 1'b0;
  logic              disp_ready;
  logic [63:0]       disp_idx;
  logic [PKT_W-1:0]  disp_data;
  logic [63:0]       disp_addr;
  logic              done_valid = 1'b0;
  logic [63:0]       done_idx = '0;
  logic [63:0]       wr_idx, rd_idx;
  logic [CNT_W-1:0]  free_cnt, inflight;
  logic              last_out;

  always #(CLK_T / 2) clk = ~clk;

  pkt_ring #(.SLOTS(SLOTS)) u_pkt_ring (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_cnt_i(alloc_cnt), .alloc_base_i(alloc_base),
    .alloc_grant_o(alloc_grant),
    .fill_valid_i(fill_valid), .fill_idx_i(fill_idx), .fill_data_i(fill_data),
    .disp_take_i(disp_take), .disp_ready_o(disp_ready), .disp_idx_o(disp_idx),
    .disp_data_o(disp_data), .disp_addr_o(disp_addr),
    .done_valid_i(done_valid), .done_idx_i(done_idx),
    .wr_idx_o(wr_idx), .rd_idx_o(rd_idx), .free_cnt_o(free_cnt),
    .inflight_o(inflight), .last_out_o(last_out)
  );

  typedef struct {
    string            req;
    int               sel;
    logic [PKT_W-1:0] exp;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    fails = 0;
  bit    finished = 1'b0;

  // reference model, stepped once per edge
  logic [63:0]      m_wr = '0, m_rd = '0, m_disp = '0;
  bit               m_done [SLOTS];
  bit               m_fill [SLOTS];
  logic [63:0]      m_addr [SLOTS];
  logic [PKT_W-1:0] m_data [SLOTS];

  function automatic logic [PKT_W-1:0] observe(int sel);
    case (sel)
      0: return PKT_W'(alloc_grant);
      1: return PKT_W'(free_cnt);
      2: return PKT_W'(inflight);
      3: return PKT_W'(wr_idx);
      4: return PKT_W'(rd_idx);
      5: return PKT_W'(disp_idx);
      6: return PKT_W'(disp_ready);
      7: return PKT_W'(last_out);
      8: return disp_data;
      default: return PKT_W'(disp_addr);
    endcase
  endfunction

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (observe(it.sel) !== it.exp) begin
        fails++;
        $display("FAIL %s output=%0d actual=%0h expected=%0h", it.req, it.sel,
                 observe(it.sel), it.exp);
      end
    end
  end

  function automatic int m_free();
    return SLOTS - int'(m_wr - m_rd);
  endfunction

  function automatic bit m_rdy();
    return (m_disp < m_wr) && m_fill[m_disp % SLOTS];
  endfunction

  function automatic bit m_last();
    if (m_rd == m_disp) return 1'b0;
    if (m_done[m_rd % SLOTS]) return 1'b0;
    for (logic [63:0] k = m_rd + 1; k < m_disp; k++)
      if (!m_done[k % SLOTS]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [PKT_W-1:0] pkt(logic [63:0] idx);
    return {8{idx ^ 64'h5A5A_0000_C3C3_0000}};
  endfunction

  task automatic push(string req, int sel, logic [PKT_W-1:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic push_state(string tag);
    push(tag == "" ? "R2" : tag, 1, PKT_W'(m_free()));
    push(tag == "" ? "R8" : tag, 2, PKT_W'(m_disp - m_rd));
    push(tag == "" ? "R2" : tag, 3, PKT_W'(m_wr));
    push(tag == "" ? "R7" : tag, 4, PKT_W'(m_rd));
    push(tag == "" ? "R6" : tag, 5, PKT_W'(m_disp));
    push(tag == "" ? "R6" : tag, 6, PKT_W'(m_rdy()));
    push(tag == "" ? "R9" : tag, 7, PKT_W'(m_last()));
    if (m_rdy()) begin
      push(tag == "" ? "R5" : tag, 8, m_data[m_disp % SLOTS]);
      push(tag == "" ? "R4" : tag, 9, PKT_W'(m_addr[m_disp % SLOTS]));
    end
  endtask

  // one edge: model step from the held inputs, then release the inputs
  task automatic cyc(string tag);
    bit g, dt, rt;
    g  = alloc_valid && (int'(alloc_cnt) <= m_free());
    dt = disp_take && m_rdy();
    rt = (m_rd != m_disp) && m_done[m_rd % SLOTS];
    if (rt) begin
      m_done[m_rd % SLOTS] = 1'b0;
      m_fill[m_rd % SLOTS] = 1'b0;
    end
    if (g) for (int i = 0; i < int'(alloc_cnt); i++)
      m_addr[(m_wr + 64'(i)) % SLOTS] = alloc_base + 64'(64 * i);
    if (fill_valid) begin
      m_data[fill_idx % SLOTS] = fill_data;
      m_fill[fill_idx % SLOTS] = 1'b1;
    end
    if (done_valid) m_done[done_idx % SLOTS] = 1'b1;
    if (g)  m_wr = m_wr + 64'(alloc_cnt);
    if (dt) m_disp = m_disp + 1;
    if (rt) m_rd = m_rd + 1;
    @(posedge clk);
    #1;
    alloc_valid = 1'b0; fill_valid = 1'b0; disp_take = 1'b0; done_valid = 1'b0;
    push_state(tag);
  endtask

  task automatic do_alloc(int n, logic [63:0] base, string tag);
    alloc_valid = 1'b1; alloc_cnt = CNT_W'(n); alloc_base = base;
    push(n <= m_free() ? "R2" : "R3", 0, PKT_W'(n <= m_free()));
    cyc(tag);
  endtask

  task automatic do_fill(logic [63:0] idx, string tag);
    fill_valid = 1'b1; fill_idx = idx; fill_data = pkt(idx);
    cyc(tag);
  endtask

  task automatic do_disp(string tag);
    disp_take = 1'b1;
    cyc(tag);
  endtask

  task automatic do_done(logic [63:0] idx, string tag);
    done_valid = 1'b1; done_idx = idx;
    cyc(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc("");
  endtask

  initial begin
    #(CLK_T * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SLOTS; s++) begin
      m_done[s] = 1'b0; m_fill[s] = 1'b0; m_addr[s] = '0; m_data[s] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    push("R1", 0, '0);
    push_state("R1");
    @(posedge clk);
    #1;

    // R2 R4 R5 R6: allocate three, fill, issue
    do_alloc(3, 64'h1000, "");
    do_disp("R6");                      // nothing filled: take ignored
    for (int i = 0; i < 3; i++) do_fill(64'(i), "R5");
    for (int i = 0; i < 3; i++) do_disp("R4");
    do_disp("R6");                      // dispatch caught up with write

    // R7 R9: out-of-order completion
    do_done(64'd1, "R7");
    do_done(64'd2, "R9");               // oldest is now the last one outstanding
    do_done(64'd0, "R7");
    idle(4);                            // retire one slot per edge

    // R3: over-sized request refused
    do_alloc(9, 64'h2000, "R3");
    do_alloc(8, 64'h8000, "R10");       // fills the ring across the wrap
    do_alloc(1, 64'h9000, "R3");        // ring full
    do_disp("R7");                      // reused slots not filled yet

    // R10: fill and issue across the wrap point
    for (int i = 3; i < 11; i++) do_fill(64'(i), "R10");
    for (int i = 0; i < 8; i++) do_disp("R10");

    // R9 R7: finish in reverse order
    for (int i = 10; i >= 3; i--) do_done(64'(i), "R9");
    idle(10);

    // R2 R6: partial refill after a full cycle
    do_alloc(2, 64'hA000, "R2");
    do_fill(64'd12, "R6");              // second slot filled first
    do_disp("R6");                      // head not filled: ignored
    do_fill(64'd11, "R5");
    do_disp("R4");
    do_disp("R4");
    do_done(64'd11, "R9");
    idle(3);

    @(negedge clk);
    #1;
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule